// File: doc/BRIEF.md
# I2S Audio Serial Transceiver

This block moves stereo PCM samples over a three-wire serial audio link: a bit clock, a frame (left/right) clock and one data line in each direction. It takes transmit words from an external queue, one word per channel slot, and shifts them out MSB first. It collects incoming bits into words and hands each completed word to an external receive queue with a one-cycle push strobe.

The block can generate both link clocks itself from a programmable divider, or it can follow clocks supplied by a codec. Data is placed either one bit after the frame-clock edge (standard I2S) or on the first bit after the edge (MSB-justified). The sample width is selectable. The transmitter can be muted. The receiver can keep a single channel only. A separate divider produces a reference clock for the codec.

Top module: `i2s_xcvr`

## Requirements
- R1: When `core_en`=1 and `ext_clocks`=0, `bit_clk_o` runs with each half period lasting `bit_div`+1 cycles of `clk`. `frame_clk_o` changes only on falling edges of `bit_clk_o`. Every channel slot lasts W bit periods, with the frame clock low for left. The first slot after enable is left.
- R2: `word_sz` values 0, 1, 2 and 3 select W = 8, 16, 24 and 32 bits. The transmitted sample is bits [W-1:0] of `tx_data`. A received word is placed in bits [W-1:0] of `rx_data` with all higher bits zero.
- R3: With `left_just`=0 the MSB is carried by the second bit of a slot. With `left_just`=1 it is carried by the first bit. Bits follow in MSB-first order in both framings.
- R4: With `tx_silence`=1 every transmitted bit is 0. Queue words are still consumed, one per slot.
- R5: The transmitter takes exactly one word per slot with `tx_pop` while the queue is not empty (`tx_empty`=0). `tx_data` is read as the word at the head of the queue.
- R6: A slot fetch that finds `tx_empty`=1 raises `xmt_starved` for one cycle, and that slot is sent as all zeros.
- R7: `xmt_busy` goes to 1 when a queue word is loaded into the shifter. It stays at 1 until the last bit of the last queued word has been sent with the queue empty.
- R8: `chan_is_right` is 1 while the word in the shifter belongs to the right slot and 0 for the left slot.
- R9: With `single_ch`=0 every received slot is pushed, in order. With `single_ch`=1 only right slots are pushed when `single_left`=0, and only left slots when `single_left`=1.
- R10: With `ext_clocks`=1 the block times itself from `bit_clk_i` and `frame_clk_i`, following the same framing rules. It holds `bit_clk_o` at 0 and `frame_clk_o` at 1, and it does the same whenever `core_en`=0.
- R11: `xmt_en`=0 stops all transmit fetches and keeps `sd_o` at 0. `rcv_en`=0 stops all pushes. Both are effective only while `core_en`=1.
- R12: `ref_clk_o` is 0 while `ref_en`=0. With `ref_en`=1, a `ref_div` of 0 passes `clk` straight through, and a nonzero N gives a period of 2N `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_en | input | 1 | Global enable |
| xmt_en | input | 1 | Transmit path enable |
| rcv_en | input | 1 | Receive path enable |
| ext_clocks | input | 1 | 1: follow external link clocks |
| left_just | input | 1 | 0: I2S framing, 1: MSB-justified |
| word_sz | input | 2 | Sample width select |
| single_ch | input | 1 | Receive one channel only |
| single_left | input | 1 | Channel kept in single-channel mode (1 = left) |
| tx_silence | input | 1 | Send zeros instead of samples |
| bit_div | input | BDIV_W | Bit clock half-period minus one |
| ref_en | input | 1 | Reference clock enable |
| ref_div | input | MDIV_W | Reference clock divider |
| bit_clk_i | input | 1 | External bit clock |
| frame_clk_i | input | 1 | External frame clock |
| sd_i | input | 1 | Serial data in |
| bit_clk_o | output | 1 | Generated bit clock |
| frame_clk_o | output | 1 | Generated frame clock |
| sd_o | output | 1 | Serial data out |
| ref_clk_o | output | 1 | Reference clock out |
| tx_data | input | 32 | Head word of transmit queue |
| tx_empty | input | 1 | Transmit queue empty |
| tx_pop | output | 1 | Consume head of transmit queue |
| xmt_starved | output | 1 | Fetch from empty queue |
| rx_data | output | 32 | Last received word |
| rx_push | output | 1 | rx_data valid strobe |
| chan_is_right | output | 1 | Shifter word is right channel |
| xmt_busy | output | 1 | Transmit data still in flight |

## Verification
The bench numbers every bit-clock rise from enable and predicts each output bit arithmetically from the framing, the width and the slot index. A wrong one-bit offset between the two framings would shift every sample by a bit, and a wrong slot length would drift the frame clock. The runs push the queue into underflow, so a transmitter that stalls instead of sending zeros, or a busy flag that never clears, shows up there. Single-channel runs catch a swapped channel select, because the kept words would come from the opposite parity. Slave-clock runs catch a frame clock sampled out of step with the synchronized bit clock.

// File: rtl/i2s_xcvr.sv
module i2s_xcvr #(
  parameter int BDIV_W = 8,
  parameter int MDIV_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_en,
  input  logic              xmt_en,
  input  logic              rcv_en,
  input  logic              ext_clocks,
  input  logic              left_just,
  input  logic [1:0]        word_sz,
  input  logic              single_ch,
  input  logic              single_left,
  input  logic              tx_silence,
  input  logic [BDIV_W-1:0] bit_div,
  input  logic              ref_en,
  input  logic [MDIV_W-1:0] ref_div,
  input  logic              bit_clk_i,
  input  logic              frame_clk_i,
  input  logic              sd_i,
  output logic              bit_clk_o,
  output logic              frame_clk_o,
  output logic              sd_o,
  output logic              ref_clk_o,
  input  logic [31:0]       tx_data,
  input  logic              tx_empty,
  output logic              tx_pop,
  output logic              xmt_starved,
  output logic [31:0]       rx_data,
  output logic              rx_push,
  output logic              chan_is_right,
  output logic              xmt_busy
);
  localparam int DW = 32;
  localparam logic [BDIV_W-1:0] BONE = 1;
  localparam logic [MDIV_W-1:0] MONE = 1;

  logic [5:0] wbits;
  assign wbits = {1'b0, word_sz, 3'b000} + 6'd8;

  // internal clock generation
  logic run_m, tick, bclk_q, lrck_q, m_fall, m_rise;
  logic [BDIV_W-1:0] bc_cnt;
  logic [5:0] slot_cnt;
  assign run_m = core_en & ~ext_clocks;
  assign tick  = (bc_cnt >= bit_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_cnt <= '0; bclk_q <= 1'b0; lrck_q <= 1'b1; slot_cnt <= '0; m_fall <= 1'b0; m_rise <= 1'b0;
    end else if (!run_m) begin
      bc_cnt <= '0; bclk_q <= 1'b0; lrck_q <= 1'b1; slot_cnt <= '0; m_fall <= 1'b0; m_rise <= 1'b0;
    end else begin
      m_fall <= tick & bclk_q;
      m_rise <= tick & ~bclk_q;
      if (tick) begin
        bc_cnt <= '0;
        bclk_q <= ~bclk_q;
        if (bclk_q) begin
          if (slot_cnt == 6'd0) begin
            lrck_q   <= ~lrck_q;
            slot_cnt <= wbits - 6'd1;
          end else begin
            slot_cnt <= slot_cnt - 6'd1;
          end
        end
      end else begin
        bc_cnt <= bc_cnt + BONE;
      end
    end
  end

  assign bit_clk_o   = bclk_q;
  assign frame_clk_o = lrck_q;

  // external clock synchronizers
  logic [2:0] sb;
  logic [1:0] sl, sd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb <= '0; sl <= 2'b11; sd <= '0;
    end else begin
      sb <= {sb[1:0], bit_clk_i};
      sl <= {sl[0], frame_clk_i};
      sd <= {sd[0], sd_i};
    end
  end

  logic fall_evt, rise_evt, lr_cur, din;
  assign fall_evt = core_en & (ext_clocks ? (sb[2] & ~sb[1]) : m_fall);
  assign rise_evt = core_en & (ext_clocks ? (~sb[2] & sb[1]) : m_rise);
  assign lr_cur   = ext_clocks ? sl[1] : lrck_q;
  assign din      = ext_clocks ? sd[1] : sd_i;

  // transmitter
  logic tx_act, lr_f, tx_pend, right_q, f_edge, load;
  logic [DW-1:0] tx_sh, fetched, aligned;
  logic [5:0] tx_left;
  assign tx_act  = core_en & xmt_en;
  assign f_edge  = fall_evt & (lr_cur != lr_f);
  assign load    = tx_act & fall_evt & (left_just ? f_edge : tx_pend);
  assign tx_pop      = load & ~tx_empty;
  assign xmt_starved = load & tx_empty;
  assign fetched = (tx_silence | tx_empty) ? '0 : tx_data;
  assign aligned = fetched << (6'd32 - wbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_f <= 1'b1; tx_pend <= 1'b0; tx_sh <= '0; tx_left <= '0; right_q <= 1'b0;
    end else begin
      if (!core_en || fall_evt) lr_f <= lr_cur;
      if (!tx_act) begin
        tx_pend <= 1'b0; tx_sh <= '0; tx_left <= '0; right_q <= 1'b0;
      end else if (fall_evt) begin
        tx_pend <= f_edge & ~left_just;
        if (load) begin
          tx_sh   <= aligned;
          tx_left <= tx_empty ? 6'd0 : wbits;
          right_q <= lr_cur;
        end else begin
          tx_sh <= tx_sh << 1;
          if (tx_left != 6'd0) tx_left <= tx_left - 6'd1;
        end
      end
    end
  end

  assign sd_o          = tx_sh[DW-1];
  assign xmt_busy      = (tx_left != 6'd0);
  assign chan_is_right = right_q;

  // receiver
  logic rx_act, lr_r, rx_pend, rx_ch, r_edge, rx_start, keep;
  logic [5:0] rx_left;
  logic [DW-1:0] rx_sh;
  assign rx_act   = core_en & rcv_en;
  assign r_edge   = rise_evt & (lr_cur != lr_r);
  assign rx_start = rx_act & rise_evt & (left_just ? r_edge : rx_pend);
  assign keep     = ~single_ch | (rx_ch == ~single_left);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_r <= 1'b1; rx_pend <= 1'b0; rx_ch <= 1'b0; rx_left <= '0;
      rx_sh <= '0; rx_data <= '0; rx_push <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (!core_en || rise_evt) lr_r <= lr_cur;
      if (!rx_act) begin
        rx_pend <= 1'b0; rx_left <= '0;
      end else if (rise_evt) begin
        rx_pend <= r_edge & ~left_just;
        if (rx_start) begin
          rx_sh   <= {{(DW-1){1'b0}}, din};
          rx_left <= wbits - 6'd1;
          rx_ch   <= lr_cur;
        end else if (rx_left != 6'd0) begin
          rx_sh   <= {rx_sh[DW-2:0], din};
          rx_left <= rx_left - 6'd1;
          if (rx_left == 6'd1 && keep) begin
            rx_data <= {rx_sh[DW-2:0], din};
            rx_push <= 1'b1;
          end
        end
      end
    end
  end

  // reference clock divider
  logic [MDIV_W-1:0] mc_cnt, mc_nxt;
  logic mclk_q;
  assign mc_nxt = mc_cnt + MONE;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_cnt <= '0; mclk_q <= 1'b0;
    end else if (!ref_en || ref_div == '0) begin
      mc_cnt <= '0; mclk_q <= 1'b0;
    end else if (mc_nxt >= ref_div) begin
      mc_cnt <= '0; mclk_q <= ~mclk_q;
    end else begin
      mc_cnt <= mc_nxt;
    end
  end
  assign ref_clk_o = ref_en & ((ref_div == '0) ? clk : mclk_q);

  AST_FRAME_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_m && $past(run_m) && (frame_clk_o != $past(frame_clk_o))) |-> $fell(bit_clk_o)); // R1
  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && $stable(word_sz)) |-> ((rx_data >> wbits) == '0)); // R2
  AST_SILENCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_silence) |=> !sd_o); // R4
  AST_STARVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    xmt_starved |=> !sd_o); // R6
  AST_BUSY_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> xmt_busy); // R7
  AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_m && $past(!run_m)) |-> (!bit_clk_o && frame_clk_o)); // R10
  AST_NO_PUSH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_act && $past(!rx_act)) |-> !rx_push); // R11
endmodule

// File: tb/i2s_xcvr_tb_top.sv
module i2s_xcvr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic core_en = 0, xmt_en = 0, rcv_en = 0, ext_clocks = 0, left_just = 0;
  logic [1:0] word_sz = 0;
  logic single_ch = 0, single_left = 0, tx_silence = 0;
  logic [7:0] bit_div = 8'd1;
  logic ref_en = 0;
  logic [2:0] ref_div = 0;
  logic bit_clk_i = 0, frame_clk_i = 1, sd_i = 0;
  logic bit_clk_o, frame_clk_o, sd_o, ref_clk_o, tx_pop, xmt_starved, rx_push, chan_is_right, xmt_busy;
  logic [31:0] rx_data, tx_data;
  logic tx_empty;

  logic [31:0] txq [0:15];
  int rd = 0, nw = 0;
  bit pop_seen = 0;
  assign tx_empty = (rd >= nw);
  assign tx_data  = txq[rd[3:0]];

  always @(negedge clk) begin
    if (pop_seen) rd++;
    pop_seen = tx_pop;
  end

  i2s_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .xmt_en(xmt_en), .rcv_en(rcv_en),
    .ext_clocks(ext_clocks), .left_just(left_just), .word_sz(word_sz), .single_ch(single_ch),
    .single_left(single_left), .tx_silence(tx_silence), .bit_div(bit_div), .ref_en(ref_en),
    .ref_div(ref_div), .bit_clk_i(bit_clk_i), .frame_clk_i(frame_clk_i), .sd_i(sd_i),
    .bit_clk_o(bit_clk_o), .frame_clk_o(frame_clk_o), .sd_o(sd_o), .ref_clk_o(ref_clk_o),
    .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop), .xmt_starved(xmt_starved),
    .rx_data(rx_data), .rx_push(rx_push), .chan_is_right(chan_is_right), .xmt_busy(xmt_busy)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] txw(int k);
    return 32'h8F1E_2D3C + k * 32'h1357_9BDF;
  endfunction
  function automatic logic [31:0] rxw(int k);
    return 32'h3C96_5AA5 ^ (k * 32'h0246_8ACF);
  endfunction
  function automatic int widx(int r, int w, bit lj);
    int base = lj ? r - 1 : r - 2;
    if (base < 0) return -1;
    return base / w;
  endfunction
  function automatic int bpos(int r, int w, bit lj);
    int base = lj ? r - 1 : r - 2;
    return w - 1 - (base % w);
  endfunction
  function automatic bit kept(int s, bit sgl, bit lft);
    if (!sgl) return 1;
    return lft ? (s % 2 == 0) : (s % 2 == 1);
  endfunction

  task automatic do_reset();
    rst_n = 0; core_en = 0; xmt_en = 0; rcv_en = 0;
    bit_clk_i = 0; frame_clk_i = 1; sd_i = 0;
    repeat (3) @(negedge clk);
    rd = 0; pop_seen = 0;
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run(bit ext, bit lj, logic [1:0] ws, int d, int ntx, bit sil, bit sgl, bit lft);
    int w = 8 * (int'(ws) + 1);
    int r = 0, f = 0, hc = 0, last_rc = -1, cyc = 0, npush = 0, nstarve = 0, s_next = 0, nexp = 0;
    bit pb = 0, b = 0;
    longint msk = (w == 32) ? 64'hFFFF_FFFF : ((64'd1 << w) - 1);
    do_reset();
    nw = ntx;
    for (int i = 0; i < 16; i++) txq[i] = txw(i);
    ext_clocks = ext; left_just = lj; word_sz = ws; bit_div = 8'(d);
    tx_silence = sil; single_ch = sgl; single_left = lft;
    xmt_en = 1; rcv_en = 1;
    @(negedge clk);
    core_en = 1;
    while (r < 8 * w + 3 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (rx_push) begin
        while (!kept(s_next, sgl, lft)) s_next++;
        chk("R9 rx word", longint'(rx_data), longint'(rxw(s_next)) & msk);
        s_next++;
        npush++;
      end
      if (xmt_starved) nstarve++;
      if (ext) begin
        hc++;
        b = bit_clk_i;
        if (hc == 6) begin hc = 0; b = ~b; end
      end else begin
        b = bit_clk_o;
      end
      if (b && !pb) begin
        int idx = widx(r, w, lj);
        bit live = (idx >= 0) && (idx < ntx);
        bit eb = (live && !sil) ? txw(idx)[bpos(r, w, lj)] : 1'b0;
        chk(sil ? "R4 muted bit" : (lj ? "R3 msbj bit" : "R3 i2s bit"), longint'(sd_o), longint'(eb));
        chk("R7 busy", longint'(xmt_busy), longint'(live));
        if (live) chk("R8 channel", longint'(chan_is_right), longint'(idx % 2));
        if (ext) begin
          chk("R10 idle bclk", longint'(bit_clk_o), 0);
          chk("R10 idle lrck", longint'(frame_clk_o), 1);
        end else begin
          chk("R1 frame", longint'(frame_clk_o), (r == 0) ? 1 : (((r - 1) / w) % 2));
          if (last_rc >= 0) chk("R1 period", cyc - last_rc, 2 * (d + 1));
          last_rc = cyc;
        end
        r++;
      end
      if (!b && pb) begin
        int idx = widx(r, w, lj);
        f++;
        if (ext) frame_clk_i = ((f - 1) / w) % 2;
        sd_i = (idx >= 0) ? rxw(idx)[bpos(r, w, lj)] : 1'b0;
      end
      if (ext) bit_clk_i = b;
      pb = b;
    end
    for (int s = 0; s < 8; s++) if (kept(s, sgl, lft)) nexp++;
    chk("R9 push count", npush, nexp);
    chk("R5 words taken", rd, ntx);
    chk("R6 starved seen", (nstarve > 0), 1);
    chk("R7 busy cleared", longint'(xmt_busy), 0);
    core_en = 0;
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int pr, last;
    do_reset();
    chk("R10 reset bclk", longint'(bit_clk_o), 0);
    chk("R10 reset lrck", longint'(frame_clk_o), 1);
    chk("R11 reset sdo", longint'(sd_o), 0);
    chk("R7 reset busy", longint'(xmt_busy), 0);
    chk("R5 reset pop", longint'(tx_pop), 0);

    for (int lj = 0; lj < 2; lj++)
      for (int ws = 0; ws < 4; ws++)
        run(0, lj[0], ws[1:0], 1, 6, 0, 0, 0);
    run(0, 0, 2'd1, 3, 6, 1, 0, 0);
    run(0, 1, 2'd1, 1, 6, 0, 1, 0);
    run(0, 0, 2'd2, 1, 6, 0, 1, 1);
    run(1, 0, 2'd1, 1, 6, 0, 0, 0);
    run(1, 1, 2'd0, 1, 6, 0, 0, 0);

    // R11: path enables off
    do_reset();
    nw = 6; left_just = 1; word_sz = 0; ext_clocks = 0; bit_div = 1;
    xmt_en = 0; rcv_en = 0; core_en = 1;
    pr = 0; last = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tx_pop) pr++;
      if (sd_o) last++;
      sd_i = i[2];
      if (rx_push) pr++;
    end
    chk("R11 no pop/push when off", pr, 0);
    chk("R11 sdo low when off", last, 0);
    core_en = 0;
    pr = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (bit_clk_o) pr++;
    end
    chk("R11 bclk idle when core off", pr, 0);

    // R12: reference clock
    ref_en = 1; ref_div = 3;
    last = -1; pr = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ref_clk_o && !pr[0]) begin
        if (last >= 0) chk("R12 div period", i - last, 6);
        last = i;
      end
      pr = int'(ref_clk_o);
    end
    ref_div = 0;
    @(negedge clk);
    chk("R12 pass low", longint'(ref_clk_o), 0);
    @(posedge clk); #1;
    chk("R12 pass high", longint'(ref_clk_o), 1);
    ref_en = 0;
    @(posedge clk); #1;
    chk("R12 disabled", longint'(ref_clk_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule